// File: doc/BRIEF.md
# Start-of-Frame Delimiter Detector with Timestamp Capture

This block sits in a receive path after preamble acquisition. It watches a stream of 4-bit symbols, each qualified by a valid strobe, and searches for a programmable one-octet start-of-frame delimiter sent as two symbols: the low-order nibble first, then the high-order nibble. Finding the delimiter gives byte alignment. The block then pulses a frame-start flag and forwards every later symbol as payload. The two delimiter symbols themselves are never forwarded. Any other delimiter value is ignored, so the node does not lock onto foreign frames.

When the timestamp enable is set, detection latches the current value of an external free-running 32-bit symbol counter into a timestamp register. That register holds its value until the next detection made with the enable set. An external end-of-frame strobe returns the detector to search.

The controller has three named states. SEEK_LO waits for the low nibble. SEEK_HI waits for the high nibble. PAYLOAD forwards symbols. The transitions are:
- LO_HIT goes from SEEK_LO to SEEK_HI.
- SFD_HIT goes from SEEK_HI to PAYLOAD.
- RETRY_LO stays in SEEK_HI when the symbol matches the low nibble.
- MISS goes from SEEK_HI to SEEK_LO.
- FRAME_END goes from any state to SEEK_LO.

Top module: `sfd_sync_detector`

## Requirements
- R1: After reset, frame_start_o, payload_valid_o and timestamp_o are all 0, and the delimiter register holds 0xA7.
- R2: A clock edge with cfg_we_i high loads cfg_sfd_i into the delimiter register. The new value is used from the next symbol on. Bits [3:0] are expected first and bits [7:4] second, and the old value no longer matches.
- R3: frame_start_o is high for exactly one cycle, in the cycle after the edge that accepts the high-order delimiter symbol.
- R4: Neither delimiter symbol produces a payload_valid_o pulse.
- R5: A symbol pair whose second symbol differs from the high nibble, and is not equal to the low nibble either, gives no frame start and no payload.
- R6: In SEEK_HI, a symbol that misses the high nibble but equals the low nibble is treated as a new first symbol.
- R7: In PAYLOAD, every valid symbol appears on payload_sym_o with payload_valid_o high in the cycle after its edge. A cycle without a valid symbol gives payload_valid_o low.
- R8: frame_end_i returns the detector to SEEK_LO from any state. A symbol presented in the same cycle is dropped, and nothing is forwarded until a new delimiter arrives.
- R9: If ts_enable_i is high at the detecting edge, timestamp_o equals the sym_count_i value at that edge. It is visible in the same cycle as frame_start_o.
- R10: timestamp_o is unchanged by a detection with ts_enable_i low, and by every cycle that is not a detection.
- R11: In PAYLOAD, symbols equal to the delimiter are forwarded as payload and do not raise frame_start_o.
- R12: Cycles without a valid symbol between the two delimiter symbols do not disturb the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Delimiter register write strobe |
| cfg_sfd_i | input | 8 | Delimiter value to write |
| sym_valid_i | input | 1 | Symbol qualifier |
| sym_i | input | 4 | Received symbol |
| frame_end_i | input | 1 | End of frame, return to search |
| ts_enable_i | input | 1 | Timestamp capture enable |
| sym_count_i | input | 32 | Free-running symbol counter |
| frame_start_o | output | 1 | One-cycle delimiter-found pulse |
| payload_valid_o | output | 1 | Payload symbol qualifier |
| payload_sym_o | output | 4 | Payload symbol |
| timestamp_o | output | 32 | Captured symbol counter value |

## Verification
All results come one register after their cause. frame_start_o, timestamp_o and each payload symbol appear in the cycle after the edge that accepted the symbol, and a delimiter write applies from the following symbol. The bench drives every input on the falling edge and lets one rising edge pass. It then samples on the next falling edge, which is exactly the cycle in which the result is due. Idle and end-of-frame cycles are checked the same way, so the bench can confirm that the pulse and the payload qualifier drop back one cycle later.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [1:0] {
        ST_SEEK_LO  = 2'd0,
        ST_SEEK_HI  = 2'd1,
        ST_PAYLOAD  = 2'd2
    } sfd_state_e;
endpackage

// File: rtl/sfd_cfg_reg.sv
module sfd_cfg_reg #(
    parameter int              OCT_W     = 8,
    parameter logic [OCT_W-1:0] RESET_VAL = 8'hA7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [OCT_W-1:0] wdata_i,
    output logic [OCT_W-1:0] value_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_o <= RESET_VAL;
        else if (we_i)
            value_o <= wdata_i;
    end
endmodule

// File: rtl/sfd_match_fsm.sv
module sfd_match_fsm
    import sfd_pkg::*;
#(
    parameter int SYM_W = 4,
    localparam int OCT_W = 2 * SYM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid_i,
    input  logic [SYM_W-1:0] sym_i,
    input  logic [OCT_W-1:0] sfd_i,
    input  logic             frame_end_i,
    output logic             hit_o,
    output logic             frame_start_o,
    output logic             payload_valid_o,
    output logic [SYM_W-1:0] payload_sym_o
);
    sfd_state_e state_q, state_d;
    logic lo_match, hi_match, accept;

    assign lo_match = (sym_i == sfd_i[SYM_W-1:0]);
    assign hi_match = (sym_i == sfd_i[OCT_W-1:SYM_W]);
    assign accept   = sym_valid_i && !frame_end_i;
    assign hit_o    = (state_q == ST_SEEK_HI) && accept && hi_match;

    // transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEEK_LO: begin
                if (accept && lo_match)          // LO_HIT
                    state_d = ST_SEEK_HI;
            end
            ST_SEEK_HI: begin
                if (frame_end_i)                 // FRAME_END
                    state_d = ST_SEEK_LO;
                else if (sym_valid_i) begin
                    if (hi_match)                // SFD_HIT
                        state_d = ST_PAYLOAD;
                    else if (lo_match)           // RETRY_LO
                        state_d = ST_SEEK_HI;
                    else                         // MISS
                        state_d = ST_SEEK_LO;
                end
            end
            ST_PAYLOAD: begin
                if (frame_end_i)                 // FRAME_END
                    state_d = ST_SEEK_LO;
            end
            default: state_d = ST_SEEK_LO;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEEK_LO;
        else
            state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_start_o   <= 1'b0;
            payload_valid_o <= 1'b0;
            payload_sym_o   <= '0;
        end else begin
            frame_start_o   <= hit_o;
            payload_valid_o <= (state_q == ST_PAYLOAD) && accept;
            if ((state_q == ST_PAYLOAD) && accept)
                payload_sym_o <= sym_i;
        end
    end
endmodule

// File: rtl/sfd_ts_latch.sv
module sfd_ts_latch #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture_i,
    input  logic [TS_W-1:0] count_i,
    output logic [TS_W-1:0] stamp_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            stamp_o <= '0;
        else if (capture_i)
            stamp_o <= count_i;
    end
endmodule

// File: rtl/sfd_sync_detector.sv
module sfd_sync_detector #(
    parameter int SYM_W           = 4,
    parameter int TS_W            = 32,
    parameter logic [2*SYM_W-1:0] SFD_RESET = 8'hA7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we_i,
    input  logic [2*SYM_W-1:0]   cfg_sfd_i,
    input  logic                 sym_valid_i,
    input  logic [SYM_W-1:0]     sym_i,
    input  logic                 frame_end_i,
    input  logic                 ts_enable_i,
    input  logic [TS_W-1:0]      sym_count_i,
    output logic                 frame_start_o,
    output logic                 payload_valid_o,
    output logic [SYM_W-1:0]     payload_sym_o,
    output logic [TS_W-1:0]      timestamp_o
);
    localparam int OCT_W = 2 * SYM_W;

    logic [OCT_W-1:0] sfd_value;
    logic             sfd_hit;

    sfd_cfg_reg #(.OCT_W(OCT_W), .RESET_VAL(SFD_RESET)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .wdata_i (cfg_sfd_i),
        .value_o (sfd_value)
    );

    sfd_match_fsm #(.SYM_W(SYM_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .sym_valid_i     (sym_valid_i),
        .sym_i           (sym_i),
        .sfd_i           (sfd_value),
        .frame_end_i     (frame_end_i),
        .hit_o           (sfd_hit),
        .frame_start_o   (frame_start_o),
        .payload_valid_o (payload_valid_o),
        .payload_sym_o   (payload_sym_o)
    );

    sfd_ts_latch #(.TS_W(TS_W)) u_ts (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (sfd_hit && ts_enable_i),
        .count_i   (sym_count_i),
        .stamp_o   (timestamp_o)
    );
endmodule

// File: rtl/sfd_sync_detector_chk.sv
module sfd_sync_detector_chk #(
    parameter int SYM_W = 4,
    parameter int TS_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid_i,
    input logic [SYM_W-1:0] sym_i,
    input logic             frame_end_i,
    input logic             ts_enable_i,
    input logic [TS_W-1:0]  sym_count_i,
    input logic             frame_start_o,
    input logic             payload_valid_o,
    input logic [SYM_W-1:0] payload_sym_o,
    input logic [TS_W-1:0]  timestamp_o
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |=> !frame_start_o);

    a_r4_no_payload_on_sfd: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> !payload_valid_o);

    a_r7_payload_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        payload_valid_o |-> ($past(sym_valid_i) && payload_sym_o == $past(sym_i)));

    a_r8_end_silences: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end_i) |-> (!payload_valid_o && !frame_start_o));

    a_r9_ts_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start_o && $past(ts_enable_i)) |-> (timestamp_o == $past(sym_count_i)));

    a_r10_ts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_o |-> $stable(timestamp_o));
endmodule

bind sfd_sync_detector sfd_sync_detector_chk #(.SYM_W(SYM_W), .TS_W(TS_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sym_valid_i     (sym_valid_i),
    .sym_i           (sym_i),
    .frame_end_i     (frame_end_i),
    .ts_enable_i     (ts_enable_i),
    .sym_count_i     (sym_count_i),
    .frame_start_o   (frame_start_o),
    .payload_valid_o (payload_valid_o),
    .payload_sym_o   (payload_sym_o),
    .timestamp_o     (timestamp_o)
);

// File: tb/sfd_sync_detector_tb.sv
`timescale 1ns/1ps
module sfd_sync_detector_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [7:0]  cfg_sfd;
    logic        sym_valid;
    logic [3:0]  sym;
    logic        frame_end;
    logic        ts_en;
    logic [31:0] sym_count;
    logic        frame_start;
    logic        payload_valid;
    logic [3:0]  payload_sym;
    logic [31:0] timestamp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [31:0] cnt = 32'h1000_0000;
    logic [31:0] ts_saved;

    always #4 clk = ~clk;

    sfd_sync_detector u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we_i        (cfg_we),
        .cfg_sfd_i       (cfg_sfd),
        .sym_valid_i     (sym_valid),
        .sym_i           (sym),
        .frame_end_i     (frame_end),
        .ts_enable_i     (ts_en),
        .sym_count_i     (sym_count),
        .frame_start_o   (frame_start),
        .payload_valid_o (payload_valid),
        .payload_sym_o   (payload_sym),
        .timestamp_o     (timestamp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at falling edge, let one rising edge pass, return at next falling edge
    task automatic step(input logic v, input logic [3:0] s, input logic e);
        sym_valid = v;
        sym       = s;
        frame_end = e;
        cnt       = cnt + 32'h0001_0203;
        sym_count = cnt;
        @(posedge clk);
        @(negedge clk);
        sym_valid = 1'b0;
        frame_end = 1'b0;
    endtask

    task automatic write_sfd(input logic [7:0] v);
        cfg_we  = 1'b1;
        cfg_sfd = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 start", {31'd0, frame_start}, 32'd0);
        check("R1 pvalid", {31'd0, payload_valid}, 32'd0);
        check("R1 ts", timestamp, 32'd0);
    endtask

    task automatic t_default_frame;
        ts_en = 1'b1;
        step(1'b1, 4'h7, 1'b0);
        check("R3 no start after low", {31'd0, frame_start}, 32'd0);
        check("R4 low not payload", {31'd0, payload_valid}, 32'd0);
        step(1'b1, 4'hA, 1'b0);
        check("R1 R3 start on A7", {31'd0, frame_start}, 32'd1);
        check("R4 high not payload", {31'd0, payload_valid}, 32'd0);
        check("R9 ts captured", timestamp, cnt);
        step(1'b1, 4'h3, 1'b0);
        check("R3 pulse one cycle", {31'd0, frame_start}, 32'd0);
        check("R7 pvalid", {31'd0, payload_valid}, 32'd1);
        check("R7 psym", {28'd0, payload_sym}, 32'h3);
        step(1'b0, 4'h0, 1'b0);
        check("R7 idle no pvalid", {31'd0, payload_valid}, 32'd0);
        step(1'b1, 4'h5, 1'b0);
        check("R7 psym 5", {28'd0, payload_sym}, 32'h5);
        step(1'b1, 4'h7, 1'b0);
        step(1'b1, 4'hA, 1'b0);
        check("R11 no restart", {31'd0, frame_start}, 32'd0);
        check("R11 sfd as payload", {27'd0, payload_valid, payload_sym}, 32'h1A);
        step(1'b1, 4'h9, 1'b1);
        check("R8 end drops symbol", {31'd0, payload_valid}, 32'd0);
        step(1'b1, 4'h3, 1'b0);
        check("R8 no forward after end", {31'd0, payload_valid}, 32'd0);
    endtask

    task automatic t_wrong_sfd;
        step(1'b1, 4'h7, 1'b0);
        step(1'b1, 4'hB, 1'b0);
        check("R5 no start", {31'd0, frame_start}, 32'd0);
        step(1'b1, 4'h3, 1'b0);
        check("R5 no payload", {31'd0, payload_valid}, 32'd0);
        step(1'b1, 4'hA, 1'b0);
        check("R5 lone high no start", {31'd0, frame_start}, 32'd0);
    endtask

    task automatic t_reexamine;
        step(1'b1, 4'h7, 1'b0);
        step(1'b1, 4'h7, 1'b0);
        check("R6 no start on 77", {31'd0, frame_start}, 32'd0);
        step(1'b1, 4'hA, 1'b0);
        check("R6 start after retry", {31'd0, frame_start}, 32'd1);
        step(1'b0, 4'h0, 1'b1);
    endtask

    task automatic t_gaps;
        step(1'b1, 4'h7, 1'b0);
        step(1'b0, 4'hA, 1'b0);
        check("R12 invalid A ignored", {31'd0, frame_start}, 32'd0);
        step(1'b0, 4'h0, 1'b0);
        step(1'b1, 4'hA, 1'b0);
        check("R12 start after gap", {31'd0, frame_start}, 32'd1);
        check("R9 ts after gap", timestamp, cnt);
        step(1'b0, 4'h0, 1'b1);
    endtask

    task automatic t_ts_hold;
        ts_en    = 1'b0;
        ts_saved = timestamp;
        step(1'b1, 4'h7, 1'b0);
        step(1'b1, 4'hA, 1'b0);
        check("R10 start", {31'd0, frame_start}, 32'd1);
        check("R10 ts held", timestamp, ts_saved);
        step(1'b0, 4'h0, 1'b1);
        ts_en = 1'b1;
        step(1'b0, 4'h0, 1'b0);
        check("R10 ts held idle", timestamp, ts_saved);
    endtask

    task automatic t_program;
        write_sfd(8'h3C);
        step(1'b1, 4'hC, 1'b0);
        step(1'b1, 4'h3, 1'b0);
        check("R2 start on 3C", {31'd0, frame_start}, 32'd1);
        check("R9 ts on 3C", timestamp, cnt);
        step(1'b0, 4'h0, 1'b1);
        step(1'b1, 4'h7, 1'b0);
        step(1'b1, 4'hA, 1'b0);
        check("R2 old sfd rejected", {31'd0, frame_start}, 32'd0);
        step(1'b1, 4'hC, 1'b0);
        step(1'b1, 4'h3, 1'b1);
        check("R8 end beats high", {31'd0, frame_start}, 32'd0);
        step(1'b1, 4'h3, 1'b0);
        check("R8 search reset", {31'd0, frame_start}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sfd = 8'h00; sym_valid = 1'b0;
        sym = 4'h0; frame_end = 1'b0; ts_en = 1'b0; sym_count = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_frame();
        t_wrong_sfd();
        t_reexamine();
        t_gaps();
        t_ts_hold();
        t_program();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule